// File: doc/BRIEF.md
# Cascadable Serial-In Latched Sink Driver

This block turns a serial bit stream into a bank of twelve sink-type on/off drive signals for loads such as print-head dots, relays or solenoids. Bits are clocked into a chain of flip-flops, one position per rising edge of the shift clock. A hold bank sits between the chain and the drive pins. While the latch control is high, the hold bank follows the chain, so a bit clocked in shows up at drive pin 0 and moves one pin further on each later edge. While the latch control is low, the hold bank keeps its contents no matter how much shifting goes on behind it.

Each drive pin is active low: it is pulled low (load on) only when its held bit is 1 and the disable input is low. An active-high disable forces every pin high (off) at once, in either latch mode. The content of the last chain stage leaves on a serial output that changes only at the rising clock edge. Wiring that output to the serial input of a second device lengthens the chain, and a single latch and disable pair then serves the wider bank. Internal state is undefined at power-up, so the disable is to be held high until a full word has been shifted and latched. The synchronous reset exists for simulation only.

Top module: `serial_latch_driver`

## Requirements
- R1: The chain has STAGES (default 12) stages: a bit driven on ser_in leaves on ser_out exactly STAGES rising edges later, and exactly 2*STAGES edges later at the second device of a two-device cascade.
- R2: On each rising clock edge, ser_in enters stage 0 and every stage k takes the previous value of stage k-1.
- R3: ser_out equals the content of the last stage (index STAGES-1) and changes only at a rising clock edge.
- R4: At each rising edge with latch_open high, every hold bit takes the value its stage holds after that edge, so a bit clocked in with latch_open high is visible on drive_n[0] right after that same edge.
- R5: At each rising edge with latch_open low, every hold bit keeps its value, whatever ser_in does.
- R6: With kill low, drive_n[k] is 0 (load on) when hold bit k is 1, and 1 (load off) when hold bit k is 0.
- R7: With kill high, every bit of drive_n is 1 without waiting for a clock edge, whether latch_open is high or low.
- R8: A clock edge with rst high clears every stage and every hold bit, so all drive_n bits are 1 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset (simulation only) |
| ser_in | input | 1 | Serial data in, enters stage 0 |
| latch_open | input | 1 | High: hold bank follows the chain; low: hold bank keeps its value |
| kill | input | 1 | High: all drive pins off |
| drive_n | output | STAGES | Active-low sink drive, bit k from hold bit k |
| ser_out | output | 1 | Last chain stage, for cascading |

## Verification
A wrong chain bit never reaches the pins directly. It comes out on ser_out after as many edges as separate its stage from the end, and it reaches drive_n on the first edge with latch_open high, at the pin matching its stage. A wrong hold bit shows on its drive pin right away while kill is low and hides completely while kill is high. The bench therefore compares every pin and both serial outputs of a two-device cascade with a 24-position reference after every edge, treating positions not yet loaded since reset as unknown and skipping them.

// File: rtl/sld_pkg.sv
`timescale 1ns/1ps
package sld_pkg;
  // Sink drive level: low turns the load on.
  function automatic logic sink_level(input logic held, input logic off);
    return off | ~held;
  endfunction
endpackage

// File: rtl/sld_shift_chain.sv
`timescale 1ns/1ps
module sld_shift_chain #(
  parameter int STAGES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  output logic [STAGES-1:0] stage_q,
  output logic [STAGES-1:0] stage_nx
);
  localparam int TOP = STAGES - 1;

  always_comb begin
    stage_nx = {stage_q[TOP-1:0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_nx;
  end

  // R2: one position per edge, new bit at stage 0
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (stage_q[0] == $past(ser_in)) &&
             (stage_q[TOP:1] == $past(stage_q[TOP-1:0])));
endmodule

// File: rtl/sld_hold_bank.sv
`timescale 1ns/1ps
module sld_hold_bank #(
  parameter int STAGES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_open,
  input  logic [STAGES-1:0] stage_nx,
  input  logic [STAGES-1:0] stage_q,
  output logic [STAGES-1:0] hold_q
);
  for (genvar k = 0; k < STAGES; k++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)             hold_q[k] <= 1'b0;
      else if (latch_open) hold_q[k] <= stage_nx[k];
    end
  end

  // R4: open hold bank matches the chain after the edge
  assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
    latch_open |=> hold_q == stage_q);

  // R5: closed hold bank keeps its value
  assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
    !latch_open |=> $stable(hold_q));
endmodule

// File: rtl/sld_out_stage.sv
`timescale 1ns/1ps
module sld_out_stage
  import sld_pkg::*;
#(
  parameter int STAGES = 12
) (
  input  logic [STAGES-1:0] hold_q,
  input  logic              kill,
  output logic [STAGES-1:0] drive_n
);
  for (genvar k = 0; k < STAGES; k++) begin : g_pin
    assign drive_n[k] = sink_level(hold_q[k], kill);
  end
endmodule

// File: rtl/serial_latch_driver.sv
`timescale 1ns/1ps
module serial_latch_driver #(
  parameter int STAGES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              latch_open,
  input  logic              kill,
  output logic [STAGES-1:0] drive_n,
  output logic              ser_out
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_nx;
  logic [STAGES-1:0] hold_q;

  sld_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst(rst), .ser_in(ser_in),
    .stage_q(stage_q), .stage_nx(stage_nx)
  );

  sld_hold_bank #(.STAGES(STAGES)) u_hold (
    .clk(clk), .rst(rst), .latch_open(latch_open),
    .stage_nx(stage_nx), .stage_q(stage_q), .hold_q(hold_q)
  );

  sld_out_stage #(.STAGES(STAGES)) u_out (
    .hold_q(hold_q), .kill(kill), .drive_n(drive_n)
  );

  assign ser_out = stage_q[TOP];

  // R3: serial output carries what stage TOP-1 held before the edge
  assert_serout_R3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ser_out == $past(stage_q[TOP-1]));

  // R6: pins follow the hold bank inverted while enabled
  assert_invert_R6: assert property (@(posedge clk) disable iff (rst)
    !kill |-> drive_n == ~hold_q);

  // R7: disable turns every pin off
  assert_kill_off_R7: assert property (@(posedge clk) disable iff (rst)
    kill |-> &drive_n);

  // R8: reset edge leaves chain clear and pins off
  assert_reset_off_R8: assert property (@(posedge clk)
    rst |=> (stage_q == '0) && (&drive_n));
endmodule

// File: tb/serial_latch_driver_bench.sv
`timescale 1ns/1ps
module serial_latch_driver_bench;
  localparam int N  = 12;
  localparam int NT = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sin = 1'b0;
  logic lo  = 1'b0;
  logic kl  = 1'b1;
  logic [N-1:0] drv_a, drv_b;
  logic so_a, so_b;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference: 0/1 known, 2 unknown
  int ref_chain [NT];
  int ref_hold  [NT];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  serial_latch_driver #(.STAGES(N)) u_serial_latch_driver (
    .clk(clk), .rst(rst), .ser_in(sin), .latch_open(lo), .kill(kl),
    .drive_n(drv_a), .ser_out(so_a)
  );

  serial_latch_driver #(.STAGES(N)) u_serial_latch_driver_b (
    .clk(clk), .rst(rst), .ser_in(so_a), .latch_open(lo), .kill(kl),
    .drive_n(drv_b), .ser_out(so_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < NT; k++) begin
      int act;
      string tag;
      act = (k < N) ? int'(drv_a[k]) : int'(drv_b[k-N]);
      if (rst)       chk("R8 reset pins off", act, 1);
      else if (kl)   chk(lo ? "R7 kill, latch open" : "R7 kill, latch closed", act, 1);
      else if (ref_hold[k] != 2) begin
        if (!lo)         tag = "R5 hold kept";
        else if (k == 0) tag = "R2 entry at pin 0";
        else             tag = "R4 ripple";
        chk(tag, act, ref_hold[k] == 1 ? 0 : 1);
      end
    end
    if (!rst && ref_chain[N-1] != 2)  chk("R3 ser_out device A", int'(so_a), ref_chain[N-1]);
    if (!rst && ref_chain[NT-1] != 2) chk("R1 ser_out after 24 edges", int'(so_b), ref_chain[NT-1]);
  endtask

  task automatic step(input logic d, input logic l, input logic k);
    sin = d; lo = l; kl = k;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NT; i++) begin ref_chain[i] = 2; ref_hold[i] = 2; end
    end else begin
      for (int i = NT - 1; i > 0; i--) ref_chain[i] = ref_chain[i-1];
      ref_chain[0] = int'(d);
      if (l) for (int i = 0; i < NT; i++) ref_hold[i] = ref_chain[i];
    end
    #2;
    compare_all();
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    for (int i = 0; i < NT; i++) begin ref_chain[i] = 2; ref_hold[i] = 2; end
    #1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);
    rst = 1'b0;
    // R7 with latch closed while loading
    for (int i = 0; i < NT; i++) step(next_bit(), 1'b0, 1'b1);
    // R7 with latch open
    for (int i = 0; i < NT; i++) step(next_bit(), 1'b1, 1'b1);
    // R2 R4 R1 R3 ripple through both devices
    for (int i = 0; i < 30; i++) step(next_bit(), 1'b1, 1'b0);
    // R5 shifting behind a closed hold bank
    for (int i = 0; i < NT; i++) step(next_bit(), 1'b0, 1'b0);
    for (int i = 0; i < NT; i++) step(1'b1, 1'b0, 1'b0);
    // R6 all ones latched: every pin on
    step(1'b1, 1'b1, 1'b0);
    chk("R6 all held ones drive low A", int'(drv_a), 0);
    chk("R6 all held ones drive low B", int'(drv_b), 0);
    // R7 immediate off without an edge
    @(negedge clk);
    kl = 1'b1;
    #1;
    chk("R7 immediate off A", int'(drv_a), (1 << N) - 1);
    chk("R7 immediate off B", int'(drv_b), (1 << N) - 1);
    kl = 1'b0;
    #1;
    chk("R6 re-enabled on", int'(drv_a), 0);
    // R6 zeros latched: every pin off
    for (int i = 0; i < NT; i++) step(1'b0, 1'b1, 1'b0);
    chk("R6 all held zeros drive high", int'(drv_b), (1 << N) - 1);
    // alternating pattern, then toggling kill with latch closed
    for (int i = 0; i < NT; i++) step(i[0], 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) step(next_bit(), 1'b0, i[0]);
    for (int i = 0; i < 8; i++) step(next_bit(), 1'b1, i[1]);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule